// File: doc/BRIEF.md
# Undervoltage reset sequencer

This block turns a digital "supply above threshold" level into a system reset. An external comparator with hysteresis drives that level. The block resynchronises the level to its clock and holds reset low while the supply is low. Once the supply comes back, it keeps reset low for a programmable power-on hold and then releases it. A single-cycle tick strobe sets the time base for every delay, so the hold and the dip filter are counted in tick periods. The hold is meant to equal the period of the downstream watchdog, so both run from the same time base.

After release, a dip in the supply forces reset again only if it lasts for a sensitivity time, counted in ticks. Shorter dips are ignored. A dip that does qualify drops reset and the "power-up complete" flag together. A downstream watchdog uses that flag to start its timing. While the flag is low, any watchdog activity is overridden, and it only comes back after a full new power-up hold. If the supply drops during the hold, the hold starts again from zero, so reset does not toggle. All pins are plain control levels with no handshake.

Top module: `uv_reset_seq`

## Requirements
- R1: While `rst_n` is low, and at any time before a complete power-up hold has run, `rst_out_n` and `pwr_done` are both 0. They stay 0 for as long as `supply_ok` remains low.
- R2: After `supply_ok` has been high for two clock cycles (the synchroniser delay), `rst_out_n` rises in the cycle that follows the POR_TICKS-th tick counted while it stays high. After the (POR_TICKS-1)-th tick, `rst_out_n` is still 0.
- R3: Once reset is released, a dip of `supply_ok` that spans fewer than SENS_TICKS ticks leaves `rst_out_n` at 1. The dip tick count returns to zero as soon as the supply is seen high again.
- R4: Once reset is released, if the synchronised `supply_ok` is low at SENS_TICKS consecutive ticks, `rst_out_n` and `pwr_done` both fall in the cycle after the last of those ticks.
- R5: During the power-up hold, any cycle in which the synchronised `supply_ok` is low clears the hold count. The full POR_TICKS ticks are then needed again.
- R6: `pwr_done` is 1 exactly when `rst_out_n` is 1.
- R7: Only cycles with `tick` high advance either delay. Any number of cycles without a tick changes neither output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block |
| tick | input | 1 | Single-cycle time-base strobe |
| supply_ok | input | 1 | Asynchronous level from the comparator, 1 = supply above threshold |
| rst_out_n | output | 1 | Active-low system reset |
| pwr_done | output | 1 | Power-up complete, enables the downstream watchdog |

## Verification
The embedded assertions check the following on every cycle:
- reset cannot be released while the synchronised supply is low (R1);
- a release happens only on a tick (R2);
- a low supply during the hold clears the hold count (R5);
- a qualified dip is followed by both outputs low (R4);
- non-tick cycles leave the timing state alone (R7);
- the dip count stays below its limit while released (R3).

Only the bench scenarios can show the exact length of the hold and of the sensitivity window. The same holds for three further behaviours:
- a short dip is ignored, and its count restarts once the supply recovers;
- an interrupted hold starts over from zero;
- long tick-free stretches change nothing at the outputs.

// File: rtl/uvr_pkg.sv
package uvr_pkg;
  typedef enum logic {
    ST_HOLD = 1'b0,
    ST_RUN  = 1'b1
  } uvr_state_e;
endpackage

// File: rtl/uvr_sync.sv
module uvr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '0;
    else        sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/uvr_dip_filter.sv
module uvr_dip_filter #(
  parameter int SENS_TICKS = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic en,
  input  logic supply_s,
  output logic uv_qual
);
  localparam int W = $clog2(SENS_TICKS + 1);

  logic [W-1:0] dc;

  assign uv_qual = en && !supply_s && tick && (dc == W'(SENS_TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        dc <= '0;
    else if (!en || supply_s || uv_qual) dc <= '0;
    else if (tick)                     dc <= dc + W'(1);
  end

  // R3: the dip count never reaches its limit while released
  p_dip_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (dc < W'(SENS_TICKS)));
endmodule

// File: rtl/uvr_hold_timer.sv
module uvr_hold_timer
  import uvr_pkg::*;
#(
  parameter int POR_TICKS = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic supply_s,
  input  logic uv_qual,
  output logic released
);
  localparam int W = $clog2(POR_TICKS + 1);

  uvr_state_e   st;
  logic [W-1:0] hc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_HOLD;
      hc <= '0;
    end else begin
      case (st)
        ST_HOLD: begin
          if (!supply_s) begin
            hc <= '0;
          end else if (tick) begin
            if (hc == W'(POR_TICKS - 1)) begin
              st <= ST_RUN;
              hc <= '0;
            end else begin
              hc <= hc + W'(1);
            end
          end
        end
        ST_RUN: begin
          if (uv_qual) begin
            st <= ST_HOLD;
            hc <= '0;
          end
        end
        default: st <= ST_HOLD;
      endcase
    end
  end

  assign released = (st == ST_RUN);

  // R1: no release while the supply is seen low
  p_no_release_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!released && !supply_s) |=> !released);
  // R5: a low supply during the hold clears the count
  p_hold_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!released && !supply_s) |=> (hc == '0));
  // R2: release only on a tick
  p_release_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(released) |-> $past(tick));
  // R7: cycles without a tick leave timing state unchanged
  p_idle_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && supply_s) |=> ($stable(hc) && $stable(released)));
endmodule

// File: rtl/uv_reset_seq.sv
module uv_reset_seq #(
  parameter int POR_TICKS   = 100,
  parameter int SENS_TICKS  = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic supply_ok,
  output logic rst_out_n,
  output logic pwr_done
);
  logic supply_s;
  logic uv_qual;
  logic released;

  uvr_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (supply_ok),
    .q     (supply_s)
  );

  uvr_dip_filter #(.SENS_TICKS(SENS_TICKS)) filt_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .en       (released),
    .supply_s (supply_s),
    .uv_qual  (uv_qual)
  );

  uvr_hold_timer #(.POR_TICKS(POR_TICKS)) hold_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .supply_s (supply_s),
    .uv_qual  (uv_qual),
    .released (released)
  );

  assign rst_out_n = released;
  assign pwr_done  = released;

  // R4: a qualified dip drops both outputs in the next cycle
  p_drop_on_qual_r4: assert property (@(posedge clk) disable iff (!rst_n)
    uv_qual |=> (!rst_out_n && !pwr_done));
endmodule

// File: tb/uv_reset_seq_tb_top.sv
module uv_reset_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int POR  = 6;
  localparam int SENS = 3;

  logic clk = 1'b0;
  logic rst_n, tick, supply_ok;
  logic rst_out_n, pwr_done;

  typedef struct {
    logic  r;
    logic  d;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uv_reset_seq #(.POR_TICKS(POR), .SENS_TICKS(SENS)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .supply_ok (supply_ok),
    .rst_out_n (rst_out_n),
    .pwr_done  (pwr_done)
  );

  task automatic cyc(input logic t);
    @(negedge clk);
    tick = t;
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      cyc(1'b1);
      cyc(1'b0);
    end
  endtask

  task automatic set_supply(input logic v);
    @(negedge clk);
    supply_ok = v;
    tick = 1'b0;
    @(posedge clk);
    #1;
    idle(3);
  endtask

  task automatic expect_out(input logic r, input logic d, input string tag);
    exp_t e;
    e.r = r; e.d = d; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // monitor: compares at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (rst_out_n !== e.r || pwr_done !== e.d) begin
          errors++;
          $display("FAIL %s: rst_out_n=%b pwr_done=%b expected %b %b",
                   e.tag, rst_out_n, pwr_done, e.r, e.d);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick = 1'b0; supply_ok = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    expect_out(1'b0, 1'b0, "R1 in reset");
    @(negedge clk); rst_n = 1'b1;
    idle(2);
    ticks(POR + 2);
    expect_out(1'b0, 1'b0, "R1 supply low keeps reset");

    // R2: exact hold length
    set_supply(1'b1);
    ticks(POR - 1);
    expect_out(1'b0, 1'b0, "R2 before last hold tick");
    ticks(1);
    expect_out(1'b1, 1'b1, "R2 released after hold");
    expect_out(1'b1, 1'b1, "R6 flag follows release");

    // R7: no ticks, long idle with supply low
    set_supply(1'b0);
    idle(40);
    expect_out(1'b1, 1'b1, "R7 no tick no qualification");

    // R3: short dip ignored
    ticks(SENS - 1);
    expect_out(1'b1, 1'b1, "R3 short dip ignored");
    set_supply(1'b1);
    expect_out(1'b1, 1'b1, "R3 recovered");
    set_supply(1'b0);
    ticks(SENS - 1);
    expect_out(1'b1, 1'b1, "R3 count restarted after recovery");

    // R4: qualified dip
    ticks(1);
    expect_out(1'b0, 1'b0, "R4 qualified dip drops both");
    set_supply(1'b1);
    ticks(1);
    expect_out(1'b0, 1'b0, "R4 hold needed after dip");

    // R5: interrupted hold restarts
    ticks(POR - 3);
    set_supply(1'b0);
    set_supply(1'b1);
    ticks(POR - 1);
    expect_out(1'b0, 1'b0, "R5 hold restarted");
    idle(50);
    expect_out(1'b0, 1'b0, "R7 hold waits for ticks");
    ticks(1);
    expect_out(1'b1, 1'b1, "R5 released after full hold");

    idle(3);
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule